// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block is a synthesizable stand-in for a small three-wire (Microwire-style) serial EEPROM. A master under test drives select, a serial clock and serial data into it and reads serial data back, just as it would with a real memory. Every signal is sampled on the system clock. A rising edge of the serial clock is found by comparing the clock with its value one system cycle earlier.

After it sees a start bit, the target collects a two-bit opcode and an address. It then performs one of five actions on an internal register array: read, write, erase-all, write-enable or write-disable. Parameters set the word width (8 or 16 bits) and the capacity in bytes. Three further options change the protocol:

- reads stop after a single word;
- one dummy clock is inserted before read data;
- special commands carry two padding bits.

Writes and erase-all start a busy period of a parameterised number of system cycles. During that period the target reports busy on its data output.

Top module: `uwire_eeprom_target`

## Requirements
- R1: An instruction begins on the first serial-clock rise, while selected, idle and not busy, at which the data input is 1. Earlier rises with data 0 are ignored. The next two bits form the opcode, sent MSB first: 10 is read, 01 is write, 00 is special. Opcode 11 does nothing until the target is deselected.
- R2: The address follows the opcode, MSB first. It is log2(bytes) bits wide for 8-bit words and one bit narrower for 16-bit words. Data words are sent MSB first.
- R3: For a read, the addressed word's MSB appears on the output after the last address bit's rise. Each later rise moves on to the next bit. After a word's last bit, output continues with the next address, and the address wraps from the top back to zero.
- R4: With the single-word option, the output stays at 1 after the first word until the target is deselected.
- R5: With the dummy-read option, the first rise after the address is consumed before the MSB is presented.
- R6: A special command is decoded from its two top address bits: 11 sets the write-enable latch, 00 clears it, 10 is erase-all and 01 does nothing. With the padding option, the action takes place on the second of two ignored bits that follow the address.
- R7: A write takes the word-width data bits that follow the address. It stores the word only if the write-enable latch is set. Without the latch, a write or erase changes nothing and causes no busy period.
- R8: Erase-all sets every bit of every word to 1.
- R9: A completed write or erase makes the target busy for BUSY_CYCLES system cycles. While busy and selected, the output is 0 and start bits are ignored. Once ready and idle, the selected output is 1.
- R10: Deselecting aborts any partial instruction and holds the output at 1. Reset clears the latch, zeroes the array and returns the decoder to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data / ready-busy status to the master |

## Verification
Most internal faults surface on the output within one serial bit:

- A wrong decoder state shows a 0 or a stale data bit where the reference expects the idle 1. It can also show a data stream shifted by a bit.
- A bad write-enable latch or array entry stays hidden until a later read of that word. The read then shows it in the first mismatching bit.
- A wrong busy count shows as the output returning to 1 too early or too late. The error appears within a cycle of the correct boundary.

Each clock's output is compared against a behavioural reference, so every such error is reported in the cycle where it first appears.

// File: rtl/uwire_eeprom_target.sv
`timescale 1ns/1ps
module uwire_eeprom_target #(
  parameter int WORD_BITS    = 16,
  parameter int MEM_BYTES    = 128,
  parameter bit SINGLE_WORD  = 1'b0,
  parameter bit EXTRA_READ   = 1'b0,
  parameter bit LONG_SPECIAL = 1'b0,
  parameter int BUSY_CYCLES  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  localparam int AW    = $clog2(MEM_BYTES) - ((WORD_BITS == 16) ? 1 : 0);
  localparam int DEPTH = 1 << AW;
  localparam int HB    = AW + 2;
  localparam int CW    = $clog2(HB + WORD_BITS + 1);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] HDR_LAST = CW'(HB - 1);
  localparam logic [CW-1:0] WD_LAST  = CW'(WORD_BITS - 1);
  localparam logic [BW-1:0] BUSY_LD  = BW'(BUSY_CYCLES);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAD, S_XRD, S_READ, S_WDATA, S_DONE} st_t;

  st_t st;
  logic sk_q, wen;
  logic [HB-2:0] hdr;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr;
  logic [WORD_BITS-1:0] sr;
  logic [BW-1:0] busy_cnt;
  logic [WORD_BITS-1:0] mem [DEPTH];

  wire sk_rise  = sel & sclk & ~sk_q;
  wire busy     = busy_cnt != '0;
  wire [HB-1:0] hdr_next = {hdr, sdi};
  wire [1:0] op = hdr_next[HB-1:HB-2];
  wire [AW-1:0] a_next = hdr_next[AW-1:0];
  wire [AW-1:0] addr_inc = addr + 1'b1;
  wire [WORD_BITS-1:0] wd_next = {sr[WORD_BITS-2:0], sdi};
  wire last_hdr = cnt == HDR_LAST;

  logic exec_spec;
  logic [1:0] spec_sel;
  always_comb begin
    exec_spec = 1'b0;
    spec_sel  = a_next[AW-1:AW-2];
    if (sk_rise && st == S_HDR && last_hdr && op == 2'b00 && !LONG_SPECIAL)
      exec_spec = 1'b1;
    if (sk_rise && st == S_PAD && cnt == CW'(1)) begin
      exec_spec = 1'b1;
      spec_sel  = addr[AW-1:AW-2];
    end
  end

  wire exec_write = sk_rise && st == S_WDATA && cnt == WD_LAST && wen;
  wire exec_erase = exec_spec && spec_sel == 2'b10 && wen;

  assign sdo = !sel ? 1'b1 : busy ? 1'b0 : (st == S_READ) ? sr[WORD_BITS-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sk_q <= 1'b0; hdr <= '0; cnt <= '0; addr <= '0; sr <= '0;
    end else begin
      sk_q <= sclk;
      if (!sel) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (sdi && !busy) begin st <= S_HDR; cnt <= '0; hdr <= '0; end
          S_HDR: begin
            hdr <= hdr_next[HB-2:0];
            cnt <= cnt + 1'b1;
            if (last_hdr) begin
              cnt  <= '0;
              addr <= a_next;
              case (op)
                2'b10: if (EXTRA_READ) st <= S_XRD;
                       else begin sr <= mem[a_next]; st <= S_READ; end
                2'b01: st <= S_WDATA;
                2'b00: st <= LONG_SPECIAL ? S_PAD : S_DONE;
                default: st <= S_DONE;
              endcase
            end
          end
          S_PAD: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(1)) st <= S_DONE;
          end
          S_XRD: begin sr <= mem[addr]; cnt <= '0; st <= S_READ; end
          S_READ: begin
            if (cnt == WD_LAST) begin
              cnt <= '0;
              if (SINGLE_WORD) st <= S_DONE;
              else begin addr <= addr_inc; sr <= mem[addr_inc]; end
            end else begin
              sr  <= sr << 1;
              cnt <= cnt + 1'b1;
            end
          end
          S_WDATA: begin
            sr  <= wd_next;
            cnt <= cnt + 1'b1;
            if (cnt == WD_LAST) st <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (exec_spec && spec_sel == 2'b11) wen <= 1'b1;
      if (exec_spec && spec_sel == 2'b00) wen <= 1'b0;
      if (exec_write || exec_erase) busy_cnt <= BUSY_LD;
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (exec_erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (exec_write) begin
      mem[addr] <= wd_next;
    end
  end

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> st == S_IDLE);
  assert_no_busy_unlatched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> busy_cnt <= $past(busy_cnt));
  assert_busy_countdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy_cnt == BW'($past(busy_cnt) - 1'b1));
  assert_start_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && busy) |=> st == S_IDLE);
  assert_latch_by_command_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen) |-> $past(sel && sclk && !sk_q));
endmodule

// File: tb/uwire_eeprom_target_bench.sv
`timescale 1ns/1ps
module uwire_eeprom_target_bench;
  localparam int BUSY = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_v [2], sk_v [2], di_v [2], dout_v [2];
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  string tag = "R10";

  int cw [2]      = '{16, 8};
  int caw [2]     = '{6, 7};
  int csingle [2] = '{0, 1};
  int cextra [2]  = '{0, 1};
  int clong [2]   = '{0, 1};

  always #5 clk = ~clk;

  uwire_eeprom_target #(.WORD_BITS(16), .MEM_BYTES(128), .BUSY_CYCLES(BUSY)) u_uwire_eeprom_target (
    .clk(clk), .rst_n(rst_n), .sel(cs_v[0]), .sclk(sk_v[0]), .sdi(di_v[0]), .sdo(dout_v[0]));
  uwire_eeprom_target #(.WORD_BITS(8), .MEM_BYTES(128), .SINGLE_WORD(1'b1), .EXTRA_READ(1'b1),
    .LONG_SPECIAL(1'b1), .BUSY_CYCLES(BUSY)) u_uwire_eeprom_target_alt (
    .clk(clk), .rst_n(rst_n), .sel(cs_v[1]), .sclk(sk_v[1]), .sdi(di_v[1]), .sdo(dout_v[1]));

  // behavioural reference: 0 idle 1 header 2 pad 3 dummy 4 read 5 wdata 6 done
  int mst [2], mcnt [2], mhdr [2], maddr [2], mbidx [2], mwd [2], mwen [2], mbusy [2], mskq [2];
  int mmem [2][128];

  task automatic m_special(int d, int s);
    if (s == 3) mwen[d] = 1;
    else if (s == 0) mwen[d] = 0;
    else if (s == 2 && mwen[d] != 0) begin
      for (int i = 0; i < (1 << caw[d]); i++) mmem[d][i] = (1 << cw[d]) - 1;
      mbusy[d] = BUSY;
    end
  endtask

  task automatic m_step(int d);
    int b0, op;
    bit rise;
    if (!rst_n) begin
      mst[d] = 0; mcnt[d] = 0; mhdr[d] = 0; maddr[d] = 0; mbidx[d] = 0; mwd[d] = 0;
      mwen[d] = 0; mbusy[d] = 0; mskq[d] = 0;
      for (int i = 0; i < 128; i++) mmem[d][i] = 0;
      return;
    end
    rise = cs_v[d] && sk_v[d] && (mskq[d] == 0);
    mskq[d] = sk_v[d];
    b0 = mbusy[d];
    if (mbusy[d] > 0) mbusy[d]--;
    if (!cs_v[d]) begin mst[d] = 0; mcnt[d] = 0; end
    else if (rise) begin
      case (mst[d])
        0: if (di_v[d] && b0 == 0) begin mst[d] = 1; mcnt[d] = 0; mhdr[d] = 0; end
        1: begin
          mhdr[d] = (mhdr[d] << 1) | int'(di_v[d]);
          mcnt[d]++;
          if (mcnt[d] == caw[d] + 2) begin
            op = (mhdr[d] >> caw[d]) & 3;
            maddr[d] = mhdr[d] & ((1 << caw[d]) - 1);
            mcnt[d] = 0;
            if (op == 2) begin
              mbidx[d] = 0;
              mst[d] = cextra[d] != 0 ? 3 : 4;
            end else if (op == 1) begin mst[d] = 5; mwd[d] = 0; end
            else if (op == 0) begin
              if (clong[d] != 0) mst[d] = 2;
              else begin m_special(d, maddr[d] >> (caw[d] - 2)); mst[d] = 6; end
            end else mst[d] = 6;
          end
        end
        2: begin
          mcnt[d]++;
          if (mcnt[d] == 2) begin m_special(d, maddr[d] >> (caw[d] - 2)); mst[d] = 6; end
        end
        3: mst[d] = 4;
        4: begin
          mbidx[d]++;
          if (mbidx[d] == cw[d]) begin
            mbidx[d] = 0;
            if (csingle[d] != 0) mst[d] = 6;
            else maddr[d] = (maddr[d] + 1) % (1 << caw[d]);
          end
        end
        5: begin
          mwd[d] = (mwd[d] << 1) | int'(di_v[d]);
          mcnt[d]++;
          if (mcnt[d] == cw[d]) begin
            mst[d] = 6;
            if (mwen[d] != 0) begin mmem[d][maddr[d]] = mwd[d]; mbusy[d] = BUSY; end
          end
        end
        default: ;
      endcase
    end
  endtask

  function automatic bit m_exp(int d);
    if (!cs_v[d]) return 1'b1;
    if (mbusy[d] > 0) return 1'b0;
    if (mst[d] == 4) return 1'((mmem[d][maddr[d]] >> (cw[d] - 1 - mbidx[d])) & 1);
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    m_step(0);
    m_step(1);
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int d = 0; d < 2; d++) begin
        checks++;
        if (dout_v[d] !== m_exp(d)) begin
          fails++;
          $display("FAIL %s dev%0d t=%0t sdo actual=%b expected=%b", tag, d, $time, dout_v[d], m_exp(d));
        end
      end
    end
  end

  task automatic check(string t, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", t, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sbit(int d, bit b, output bit smp);
    di_v[d] = b; sk_v[d] = 1'b0; tick(2);
    smp = dout_v[d];
    sk_v[d] = 1'b1; tick(2);
  endtask

  task automatic select(int d);
    sk_v[d] = 1'b0; cs_v[d] = 1'b1; tick(1);
  endtask

  task automatic deselect(int d);
    sk_v[d] = 1'b0; cs_v[d] = 1'b0; di_v[d] = 1'b0; tick(2);
  endtask

  task automatic send_hdr(int d, int op, int addr);
    bit s;
    sbit(d, 1'b1, s);
    sbit(d, 1'((op >> 1) & 1), s);
    sbit(d, 1'(op & 1), s);
    for (int i = caw[d] - 1; i >= 0; i--) sbit(d, 1'((addr >> i) & 1), s);
  endtask

  task automatic wr(int d, int addr, int data);
    bit s;
    select(d);
    send_hdr(d, 1, addr);
    for (int i = cw[d] - 1; i >= 0; i--) sbit(d, 1'((data >> i) & 1), s);
    deselect(d);
    tick(BUSY + 5);
  endtask

  task automatic special(int d, int s);
    bit x;
    select(d);
    send_hdr(d, 0, s << (caw[d] - 2));
    if (clong[d] != 0) begin sbit(d, 1'b0, x); sbit(d, 1'b1, x); end
    deselect(d);
    if (s == 2) tick(BUSY + 5);
  endtask

  task automatic rd(int d, int addr, int nbits, output int v);
    bit s;
    select(d);
    send_hdr(d, 2, addr);
    if (cextra[d] != 0) sbit(d, 1'b0, s);
    v = 0;
    for (int i = 0; i < nbits; i++) begin sbit(d, 1'b0, s); v = (v << 1) | int'(s); end
    deselect(d);
  endtask

  initial begin
    int v;
    bit s;
    for (int d = 0; d < 2; d++) begin cs_v[d] = 0; sk_v[d] = 0; di_v[d] = 0; end
    tick(3);
    rst_n = 1'b1;
    tick(2);
    tag = "R10";
    check("R10 reset deselected output", int'(dout_v[0]), 1);
    select(0);
    check("R10 R9 reset selected idle output", int'(dout_v[0]), 1);
    deselect(0);

    tag = "R7";
    wr(0, 5, 16'h1234);
    rd(0, 5, 16, v);
    check("R7 write without latch ignored", v, 0);

    tag = "R6";
    special(0, 3);
    tag = "R2";
    wr(0, 5, 16'hA5C3);
    rd(0, 5, 16, v);
    check("R2 R7 stored word MSB first", v, 16'hA5C3);

    tag = "R9";
    select(0);
    send_hdr(0, 1, 12);
    for (int i = 15; i >= 0; i--) sbit(0, 1'((16'h0F0F >> i) & 1), s);
    tick(2);
    check("R9 busy output low while selected", int'(dout_v[0]), 0);
    tick(BUSY);
    check("R9 ready output high", int'(dout_v[0]), 1);
    deselect(0);

    wr(0, 63, 16'hBEEF);
    wr(0, 0, 16'h1111);
    tag = "R3";
    rd(0, 63, 32, v);
    check("R3 sequential read wraps to zero", v, 32'hBEEF1111);
    rd(0, 11, 32, v);
    check("R3 sequential read across words", v, 32'h00000F0F);

    tag = "R10";
    select(0);
    send_hdr(0, 1, 7);
    for (int i = 0; i < 5; i++) sbit(0, 1'b1, s);
    deselect(0);
    tick(BUSY + 5);
    rd(0, 7, 16, v);
    check("R10 aborted write leaves word", v, 0);

    tag = "R9";
    select(0);
    send_hdr(0, 1, 9);
    for (int i = 15; i >= 0; i--) sbit(0, 1'((16'h2222 >> i) & 1), s);
    deselect(0);
    select(0);
    for (int i = 0; i < 3; i++) begin
      sbit(0, 1'b1, s);
      check("R9 start ignored while busy", int'(s), 0);
    end
    deselect(0);
    tick(BUSY + 5);
    rd(0, 9, 16, v);
    check("R9 word written before busy", v, 16'h2222);

    tag = "R1";
    select(0);
    sbit(0, 1'b0, s);
    sbit(0, 1'b0, s);
    send_hdr(0, 2, 5);
    v = 0;
    for (int i = 0; i < 16; i++) begin sbit(0, 1'b0, s); v = (v << 1) | int'(s); end
    deselect(0);
    check("R1 leading zeros before start bit", v, 16'hA5C3);
    select(0);
    send_hdr(0, 3, 5);
    sbit(0, 1'b1, s);
    check("R1 opcode 11 idle output", int'(dout_v[0]), 1);
    deselect(0);

    tag = "R6";
    special(0, 1);
    special(0, 0);
    wr(0, 5, 16'hFFFF);
    rd(0, 5, 16, v);
    check("R6 R7 write after disable ignored", v, 16'hA5C3);
    special(0, 2);
    rd(0, 5, 16, v);
    check("R7 erase without latch ignored", v, 16'hA5C3);

    tag = "R8";
    special(0, 3);
    special(0, 2);
    rd(0, 0, 32, v);
    check("R8 erase-all sets ones", v, 32'hFFFFFFFF);
    rd(0, 40, 16, v);
    check("R8 erase-all other word", v, 16'hFFFF);

    tag = "R5";
    special(1, 3);
    wr(1, 3, 8'h5A);
    wr(1, 4, 8'hC3);
    rd(1, 3, 8, v);
    check("R5 R6 dummy cycle then data", v, 8'h5A);
    tag = "R4";
    rd(1, 4, 16, v);
    check("R4 single word then high", v, 16'hC3FF);
    special(1, 0);
    wr(1, 4, 8'h00);
    rd(1, 4, 8, v);
    check("R6 padded disable blocks write", v, 8'hC3);

    tick(4);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule